// File: doc/BRIEF.md
# Frame-Synchronous Parallel Descrambler

This block removes the frame-synchronous scrambling from received STS-48 traffic, four bytes at a time. Each clock it can take one 32-bit word, along with a valid strobe, a frame-start marker on the word that carries the first A1 byte, and a payload marker. It returns the word one clock later, with the markers delayed by the same amount. The key sequence comes from a seven-stage generator with polynomial 1 + x^6 + x^7. The generator restarts from all ones at the first byte after the unscrambled first-row overhead, and it then runs over every remaining byte of the frame.

The block counts words from each frame-start marker. The first 36 words of a frame hold the 48 A1, 48 A2 and 48 J0 bytes, and they leave the block unchanged. If no new marker arrives after a full frame of 9720 words, the count wraps around. A per-word inhibit control bypasses the descrambling, but the sequence keeps its place. Before the first frame-start marker has been seen, all data passes through unchanged.

Top module: `sts_descrambler`

## Requirements
- R1: `validOut`, `frameOut` and `speOut` equal `validIn`, `frameIn` and `speIn` of the previous clock. `dataOut` is the word accepted on the previous clock, after processing.
- R2: While `rstN` is low, all outputs are zero.
- R3: Until a word is accepted with `frameIn` high, every accepted word passes through unchanged.
- R4: Word positions are counted from 0, and the word accepted with `frameIn` high is position 0. Positions 0 to 35 pass through unchanged.
- R5: From position 36 onward, the data is XORed with the key sequence. The generator holds a 7-bit state s[6:0] and emits s[6], then moves to {s[5:0], s[6]^s[5]}. It is loaded with 7'h7F for position 36 and steps 32 times per word. Bit 31 of each word is the earliest bit, so bit 7 of each byte is that byte's earliest bit. With all-zero input data, position 36 therefore reads 32'hFE041851.
- R6: A word accepted with `inhibitIn` high passes through unchanged. The sequence still advances over that word, so later words get the same key they would have had without the inhibit.
- R7: A frame-start marker in the middle of a frame restarts the count at 0 for that word.
- R8: After position 9719, if no marker arrives, the next accepted word is position 0 and a new sequence cycle follows.
- R9: When `validIn` is low, no word is consumed. The position and sequence do not move, `validOut`, `frameOut` and `speOut` are low on the next clock, and `dataOut` holds its value.
- R10: `frameIn` is ignored while `validIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 32 | Received word, earliest byte in bits 31:24 |
| validIn | input | 1 | Word present on `dataIn` |
| frameIn | input | 1 | Word holds the first A1 byte of a frame |
| speIn | input | 1 | Payload marker, delayed unchanged |
| inhibitIn | input | 1 | Bypass descrambling for this word |
| dataOut | output | 32 | Processed word |
| validOut | output | 1 | Delayed valid |
| frameOut | output | 1 | Delayed frame-start marker |
| speOut | output | 1 | Delayed payload marker |

## Verification
The assertions check a set of rules on every cycle:
- the one-clock delay of the markers;
- the pass-through of inhibited words;
- quiet markers after idle cycles;
- the restart and wrap of the position count;
- the generator reload to all ones, and the generator never reaching the all-zero lock-up state.

Only the bench scenarios can show that the key matches the sequence bit for bit, including the known first word, across:
- an inhibited stretch;
- gaps in valid;
- a mid-frame restart;
- the natural wrap after a full frame.

Those scenarios also show that data before the first marker is left alone.

// File: rtl/dscr_pkg.sv
package dscr_pkg;

  // Per-word strobes from control to datapath
  typedef struct packed {
    logic take;      // a word is consumed this cycle
    logic loadSeed;  // reload generator with all ones
    logic advance;   // step generator one word
    logic apply;     // XOR key onto the word
  } dscrStrobe_t;

endpackage

// File: rtl/dscr_keygen.sv
module dscr_keygen #(
  parameter int LFSR_W = 7,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadSeed,
  input  logic              advance,
  output logic [WORD_W-1:0] keyWord
);

  localparam int OUT_W = WORD_W + LFSR_W;

  logic [LFSR_W-1:0] seqState;
  logic [LFSR_W-1:0] stepState;

  // Unrolled WORD_W serial steps; first emitted bit lands in the MSB
  function automatic logic [OUT_W-1:0] runWord(input logic [LFSR_W-1:0] s0);
    logic [LFSR_W-1:0] s;
    logic [WORD_W-1:0] k;
    s = s0;
    k = '0;
    for (int i = 0; i < WORD_W; i++) begin
      k[WORD_W-1-i] = s[LFSR_W-1];
      s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
    end
    return {k, s};
  endfunction

  assign {keyWord, stepState} = runWord(seqState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= '1;
    end else if (loadSeed) begin
      seqState <= '1;
    end else if (advance) begin
      seqState <= stepState;
    end
  end

  // R5: seed reload lands as all ones
  a_r5_seed_load: assert property (@(posedge clk) disable iff (!rstN)
    loadSeed |=> seqState == '1);

  // R5: maximal-length generator never reaches the lock-up state
  a_r5_state_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    seqState != '0);

  // R9: no step without a consumed word
  a_r9_state_hold: assert property (@(posedge clk) disable iff (!rstN)
    !loadSeed && !advance |=> $stable(seqState));

endmodule

// File: rtl/dscr_ctrl.sv
module dscr_ctrl
  import dscr_pkg::*;
#(
  parameter int FRAME_WORDS = 9720,
  parameter int OH_WORDS    = 36
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        frameIn,
  input  logic        inhibitIn,
  output dscrStrobe_t strobe
);

  localparam int IDX_W = $clog2(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0] OH_END   = IDX_W'(OH_WORDS);

  logic [IDX_W-1:0] nextIdx;   // position of the next accepted word
  logic [IDX_W-1:0] curIdx;    // position of the word on the inputs
  logic             synced;
  logic             curSynced;
  logic             inOh;
  logic             scrambled;

  always_comb begin
    curIdx    = frameIn ? '0 : nextIdx;
    curSynced = synced | frameIn;
    inOh      = curIdx < OH_END;
    scrambled = validIn & curSynced & ~inOh;

    strobe.take     = validIn;
    strobe.loadSeed = validIn & inOh;
    strobe.advance  = scrambled;
    strobe.apply    = scrambled & ~inhibitIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextIdx <= '0;
      synced  <= 1'b0;
    end else if (validIn) begin
      nextIdx <= (curIdx == LAST_IDX) ? '0 : curIdx + IDX_W'(1);
      synced  <= curSynced;
    end
  end

  // R7: a marked word is position 0, so the next one is position 1
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    validIn && frameIn |=> nextIdx == IDX_W'(1));

  // R8: count wraps after the last position of a frame
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rstN)
    validIn && !frameIn && nextIdx == LAST_IDX |=> nextIdx == '0);

  // R10: idle cycles, marker or not, leave position and sync untouched
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(nextIdx) && $stable(synced));

endmodule

// File: rtl/dscr_datapath.sv
module dscr_datapath
  import dscr_pkg::*;
#(
  parameter int LFSR_W = 7,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dscrStrobe_t       strobe,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              frameIn,
  input  logic              speIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              validOut,
  output logic              frameOut,
  output logic              speOut
);

  logic [WORD_W-1:0] keyWord;

  dscr_keygen #(
    .LFSR_W(LFSR_W),
    .WORD_W(WORD_W)
  ) u_keygen (
    .clk     (clk),
    .rstN    (rstN),
    .loadSeed(strobe.loadSeed),
    .advance (strobe.advance),
    .keyWord (keyWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut  <= '0;
      validOut <= 1'b0;
      frameOut <= 1'b0;
      speOut   <= 1'b0;
    end else begin
      validOut <= strobe.take;
      frameOut <= strobe.take & frameIn;
      speOut   <= strobe.take & speIn;
      if (strobe.take) begin
        dataOut <= strobe.apply ? (dataIn ^ keyWord) : dataIn;
      end
    end
  end

  // R9: output word held through idle cycles
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(dataOut));

endmodule

// File: rtl/sts_descrambler.sv
module sts_descrambler
  import dscr_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int LFSR_W      = 7,
  parameter int FRAME_WORDS = 9720,
  parameter int OH_WORDS    = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              validIn,
  input  logic              frameIn,
  input  logic              speIn,
  input  logic              inhibitIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              validOut,
  output logic              frameOut,
  output logic              speOut
);

  dscrStrobe_t strobe;

  dscr_ctrl #(
    .FRAME_WORDS(FRAME_WORDS),
    .OH_WORDS   (OH_WORDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .frameIn  (frameIn),
    .inhibitIn(inhibitIn),
    .strobe   (strobe)
  );

  dscr_datapath #(
    .LFSR_W(LFSR_W),
    .WORD_W(WORD_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .frameIn (frameIn),
    .speIn   (speIn),
    .dataOut (dataOut),
    .validOut(validOut),
    .frameOut(frameOut),
    .speOut  (speOut)
  );

  // R1: markers delayed by exactly one clock
  a_r1_frame_delay: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> frameOut == $past(frameIn) && speOut == $past(speIn) && validOut);

  // R6: inhibited word leaves unchanged
  a_r6_inhibit_pass: assert property (@(posedge clk) disable iff (!rstN)
    validIn && inhibitIn |=> dataOut == $past(dataIn));

  // R10: markers quiet after an idle cycle
  a_r10_gap_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut && !frameOut && !speOut);

endmodule

// File: tb/sts_descrambler_tb.sv
`timescale 1ns/1ps
module sts_descrambler_tb;

  localparam int FW = 9720;
  localparam int OH = 36;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic        validIn = 1'b0;
  logic        frameIn = 1'b0;
  logic        speIn = 1'b0;
  logic        inhibitIn = 1'b0;
  logic [31:0] dataOut;
  logic        validOut;
  logic        frameOut;
  logic        speOut;

  always #2 clk = ~clk;

  sts_descrambler u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .validIn(validIn),
    .frameIn(frameIn), .speIn(speIn), .inhibitIn(inhibitIn),
    .dataOut(dataOut), .validOut(validOut), .frameOut(frameOut), .speOut(speOut)
  );

  typedef struct {
    logic [31:0] data;
    bit          fr;
    bit          sp;
    bit          knownFirst;
    string       tag;
  } expItem_t;

  expItem_t    sbq[$];
  int          checks = 0;
  int          failures = 0;
  bit          monOn = 1'b0;
  bit          done = 1'b0;
  logic [31:0] lastOut = '0;

  // reference model state
  logic [6:0]  mState = 7'h7F;
  int          mIdx = 0;
  bit          mSynced = 1'b0;
  string       phase = "R5";

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] d, bit fr, bit sp, bit inh, bit v);
    expItem_t it;
    int          ci;
    bit          cs;
    logic [31:0] key;
    @(negedge clk);
    dataIn = d; frameIn = fr; speIn = sp; inhibitIn = inh; validIn = v;
    if (v) begin
      ci  = fr ? 0 : mIdx;
      cs  = mSynced | fr;
      key = '0;
      if (ci < OH) begin
        mState = 7'h7F;
      end else if (cs) begin
        for (int b = 31; b >= 0; b--) begin
          key[b] = mState[6];
          mState = {mState[5:0], mState[6] ^ mState[5]};
        end
      end
      it.data       = (cs && ci >= OH && !inh) ? (d ^ key) : d;
      it.fr         = fr;
      it.sp         = sp;
      it.knownFirst = (cs && ci == OH && d == 32'h0 && !inh);
      if (!cs)           it.tag = "R3";
      else if (ci < OH)  it.tag = "R4";
      else if (inh)      it.tag = "R6";
      else               it.tag = phase;
      sbq.push_back(it);
      mIdx    = (ci == FW - 1) ? 0 : ci + 1;
      mSynced = cs;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    expItem_t it;
    #1;
    if (monOn) begin
      if (validOut) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R1", "unexpected output word", dataOut, 32'h0);
        end else begin
          it = sbq.pop_front();
          check(dataOut == it.data, it.tag, "data word", dataOut, it.data);
          check(frameOut == it.fr, "R1", "frame marker", {31'h0, frameOut}, {31'h0, it.fr});
          check(speOut == it.sp, "R1", "payload marker", {31'h0, speOut}, {31'h0, it.sp});
          if (it.knownFirst)
            check(dataOut == 32'hFE041851, "R5", "first key word", dataOut, 32'hFE041851);
        end
      end else begin
        check(!frameOut && !speOut, "R9", "markers during gap",
              {30'h0, frameOut, speOut}, 32'h0);
        check(dataOut == lastOut, "R9", "data held during gap", dataOut, lastOut);
      end
      lastOut = dataOut;
    end
  end

  task automatic runWords(int n, bit gaps, bit inhs);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 17 == 5)) drive($urandom, 1'b0, 1'b0, 1'b0, 1'b0);
      drive($urandom, 1'b0, (mIdx % 90) > 3, inhs && (i % 23 < 3), 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dataOut == 0 && !validOut && !frameOut && !speOut, "R2", "reset outputs",
          {dataOut[31:3], validOut, frameOut, speOut}, 32'h0);
    rstN = 1'b1;
    monOn = 1'b1;

    // R3: unsynced words pass through
    runWords(8, 1'b0, 1'b0);
    // R10: marker with valid low is ignored
    drive(32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
    runWords(3, 1'b0, 1'b0);

    // R4 overhead words, then R5 known first key word
    drive($urandom, 1'b1, 1'b0, 1'b0, 1'b1);
    runWords(OH - 1, 1'b1, 1'b0);
    drive(32'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    // R5 with gaps, R6 inhibited stretches
    runWords(300, 1'b1, 1'b1);

    // run to the natural wrap, then R8
    while (mIdx != 0) drive($urandom, 1'b0, 1'b1, 1'b0, 1'b1);
    phase = "R8";
    runWords(OH, 1'b0, 1'b0);
    drive(32'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    runWords(60, 1'b1, 1'b1);

    // R7: mid-frame restart
    phase = "R7";
    runWords(100, 1'b0, 1'b0);
    drive($urandom, 1'b1, 1'b0, 1'b0, 1'b1);
    runWords(OH - 1, 1'b0, 1'b0);
    drive(32'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    runWords(80, 1'b1, 1'b1);

    // drain
    repeat (4) drive('0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(sbq.size() == 0, "R1", "words left in scoreboard", sbq.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule